// File: doc/BRIEF.md
# Configurable SPI Frame Shift Engine

This block is the serial core of a synchronous serial master. It takes parallel words from a transmit queue, sends them out on the serial data line most significant bit first, and assembles the bits it receives into words for a receive queue. Each frame can be 4 to 16 bits long. The frame size, the clock polarity and the clock phase are set through configuration inputs. The data queues, the register decode and the bit-rate divider are separate blocks. The queues connect through valid/ready and valid-only handshakes. The divider supplies a one-cycle `bit_tick` pulse, and each pulse produces one edge of the serial clock.

An enable input gates the engine. While it is low, no word is taken from the transmit queue. If it drops during a frame, the frame is aborted and the serial clock returns to its idle level. A loopback input feeds the outgoing data line straight into the receiver, so the core can be tested without an attached device. A busy output is high while a frame is in flight or a transmit word is still waiting.

Top module: `spi_frame_shifter`

## Requirements
- R1: The frame length is `cfg_size`+1 bits for `cfg_size` values 3 through 15, giving 4 to 16 bits. Size values 0, 1 and 2 are treated as 4-bit frames.
- R2: Bits are sent most significant first. Only the low N bits of `tx_data` are sent in an N-bit frame, and the upper bits have no effect.
- R3: With `cfg_phase`=0, the first bit is on `mosi` before the first SCLK edge. Both sides sample on leading edges, and the data changes on trailing edges.
- R4: With `cfg_phase`=1, the data changes on leading edges (never on the first one) and is sampled on trailing edges.
- R5: When no frame is active, `sclk` equals `cfg_pol`. This holds after reset and between frames. A leading edge is an edge away from that idle level.
- R6: While `cfg_en`=0, `tx_ready` stays low and no receive word is produced. Clearing `cfg_en` during a frame aborts it: on the next cycle `sclk` is back at idle and the partial frame is never delivered.
- R7: With `cfg_loop`=1, the receiver samples the engine's own `mosi` and `miso` is ignored.
- R8: A received frame appears on `rx_data` zero-extended to 16 bits. `rx_valid` is high for exactly the cycle whose tick samples the last bit.
- R9: `busy` is high whenever `tx_valid` is high or a frame is in progress, and low otherwise.
- R10: Each `bit_tick` during a frame produces exactly one SCLK edge. An N-bit frame has exactly 2N edges, and `sclk` holds between ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 4 | Frame length minus one |
| cfg_phase | input | 1 | Clock phase select |
| cfg_pol | input | 1 | Idle level of SCLK |
| cfg_en | input | 1 | Engine enable; low aborts and holds off |
| cfg_loop | input | 1 | Route mosi to the receiver |
| bit_tick | input | 1 | One pulse per SCLK half period |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | 16 | Transmit word, low N bits used |
| tx_ready | output | 1 | Word taken this cycle (pop) |
| rx_valid | output | 1 | Received word valid this cycle (push) |
| rx_data | output | 16 | Received word, zero-extended |
| miso | input | 1 | Serial data from the device |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| busy | output | 1 | Frame active or transmit word pending |

## Verification
The hardest case to reach from the ports is an abort in the middle of a frame. Enable must drop after the engine has taken the word but before the tick that samples the last bit, and nothing from that frame may show up afterwards. The bench starts a 16-bit frame with idle-high polarity, waits a fixed number of cycles so that the abort lands mid-frame, and then clears the enable. The scoreboard's receive queue is left empty, so any stray `rx_valid` counts as a miscompare. Phase handling is checked by a bench-side device model that sees SCLK only through its edges and shifts its own word the opposite way.

// File: rtl/spi_fse_pkg.sv
package spi_fse_pkg;
  localparam int WORD_W   = 16;
  localparam int SIZE_W   = 4;
  localparam int LEN_W    = $clog2(WORD_W + 1);
  localparam int HALF_W   = LEN_W + 1;
  localparam int MIN_BITS = 4;

  // frame length from the size field, clamped to the legal minimum
  function automatic logic [LEN_W-1:0] frame_bits(input logic [SIZE_W-1:0] sz);
    logic [LEN_W-1:0] n;
    n = LEN_W'(sz) + LEN_W'(1);
    if (n < LEN_W'(MIN_BITS)) n = LEN_W'(MIN_BITS);
    return n;
  endfunction

  // move the low n bits of a word to the top for MSB-first shifting
  function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] w,
                                                   input logic [LEN_W-1:0] n);
    return w << (LEN_W'(WORD_W) - n);
  endfunction

  // index of the final half period of an n-bit frame
  function automatic logic [HALF_W-1:0] half_last(input logic [LEN_W-1:0] n);
    return {n, 1'b0} - HALF_W'(1);
  endfunction
endpackage

// File: rtl/spi_fse_timer.sv
module spi_fse_timer
  import spi_fse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic [LEN_W-1:0] len_in,
  input  logic             cpha_in,
  input  logic             cpol_in,
  input  logic             cpol_live,
  output logic             active,
  output logic [LEN_W-1:0] len_q,
  output logic             sample_ev,
  output logic             shift_ev,
  output logic             last_sample,
  output logic             sclk
);
  logic [HALF_W-1:0] half;
  logic              cpha_q;
  logic              cpol_q;
  logic              lvl;
  logic              step;
  logic              final_ev;

  assign step        = active & tick & ~abort;
  assign sample_ev   = step & (half[0] == cpha_q);
  assign shift_ev    = step & (half[0] != cpha_q) & ~(cpha_q & (half == '0));
  assign final_ev    = step & (half == half_last(len_q));
  assign last_sample = sample_ev & (half[HALF_W-1:1] == (len_q - LEN_W'(1)));
  assign sclk        = active ? (cpol_q ^ lvl) : cpol_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      half   <= '0;
      len_q  <= LEN_W'(MIN_BITS);
      cpha_q <= 1'b0;
      cpol_q <= 1'b0;
      lvl    <= 1'b0;
    end else if (abort) begin
      active <= 1'b0;
      half   <= '0;
      lvl    <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      half   <= '0;
      lvl    <= 1'b0;
      len_q  <= len_in;
      cpha_q <= cpha_in;
      cpol_q <= cpol_in;
    end else if (step) begin
      lvl  <= ~lvl;
      half <= half + HALF_W'(1);
      if (final_ev) begin
        active <= 1'b0;
        half   <= '0;
      end
    end
  end

  assert_clock_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !abort) |=> $stable(sclk));

  assert_half_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (half <= half_last(len_q)));

  assert_frame_ends_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    final_ev |=> (!active && lvl == 1'b0));
endmodule

// File: rtl/spi_fse_tx.sv
module spi_fse_tx
  import spi_fse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [LEN_W-1:0]  len,
  input  logic              shift,
  output logic              mosi
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= left_align(word, len);
    else if (shift) sreg <= {sreg[WORD_W-2:0], 1'b0};
  end

  assign mosi = sreg[WORD_W-1];

  assert_load_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mosi == word[len - LEN_W'(1)]));
endmodule

// File: rtl/spi_fse_rx.sv
module spi_fse_rx
  import spi_fse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              last,
  input  logic              in_bit,
  input  logic [LEN_W-1:0]  len,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  logic [WORD_W-2:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap <= '0;
    else if (clear)  cap <= '0;
    else if (sample) cap <= {cap[WORD_W-3:0], in_bit};
  end

  assign rx_valid = last;
  assign rx_data  = {cap, in_bit};

  assert_zero_extend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> len) == '0));
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_fse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              cfg_phase,
  input  logic              cfg_pol,
  input  logic              cfg_en,
  input  logic              cfg_loop,
  input  logic              bit_tick,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy
);
  logic             active;
  logic [LEN_W-1:0] len_in;
  logic [LEN_W-1:0] len_q;
  logic             sample_ev;
  logic             shift_ev;
  logic             last_sample;
  logic             start;
  logic             rx_in;

  assign len_in   = frame_bits(cfg_size);
  assign start    = cfg_en & ~active & tx_valid;
  assign tx_ready = start;
  assign rx_in    = cfg_loop ? mosi : miso;
  assign busy     = active | tx_valid;

  spi_fse_timer u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .abort       (~cfg_en),
    .tick        (bit_tick),
    .len_in      (len_in),
    .cpha_in     (cfg_phase),
    .cpol_in     (cfg_pol),
    .cpol_live   (cfg_pol),
    .active      (active),
    .len_q       (len_q),
    .sample_ev   (sample_ev),
    .shift_ev    (shift_ev),
    .last_sample (last_sample),
    .sclk        (sclk)
  );

  spi_fse_tx u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .word  (tx_data),
    .len   (len_in),
    .shift (shift_ev),
    .mosi  (mosi)
  );

  spi_fse_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .sample   (sample_ev),
    .last     (last_sample),
    .in_bit   (rx_in),
    .len      (len_q),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

  assert_accept_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> cfg_en);

  assert_silent_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !rx_valid);

  assert_busy_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> busy);
endmodule

// File: tb/sim_spi_frame_shifter.sv
`timescale 1ns/100ps
module sim_spi_frame_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_size = 4'd7;
  logic        cfg_phase = 1'b0, cfg_pol = 1'b0, cfg_en = 1'b0, cfg_loop = 1'b0;
  logic        bit_tick = 1'b0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_ready, rx_valid, sclk, mosi, busy, miso;
  logic [15:0] rx_data;

  int vectors = 0, miscompares = 0;
  logic [15:0] exp_mosi_q[$];
  logic [15:0] exp_rx_q[$];

  // device model state
  logic        arm = 1'b0, was_arm = 1'b0, prev_sclk = 1'b0;
  int          slv_n = 8, ec = 0;
  logic        slv_pol = 1'b0, slv_pha = 1'b0;
  logic [15:0] slv_word = '0, sw = '0, mw = '0;
  int          tcnt = 0;

  assign miso = sw[15];

  always #2.5 clk = ~clk;

  spi_frame_shifter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_phase(cfg_phase),
    .cfg_pol(cfg_pol), .cfg_en(cfg_en), .cfg_loop(cfg_loop), .bit_tick(bit_tick),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .miso(miso), .sclk(sclk),
    .mosi(mosi), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // tick generator: one pulse every third cycle
  initial begin
    forever begin
      @(negedge clk);
      tcnt = (tcnt == 2) ? 0 : tcnt + 1;
      bit_tick = (tcnt == 0);
    end
  end

  // device model and receive monitor
  initial begin
    logic lead;
    logic [15:0] e;
    forever begin
      @(negedge clk); #1;
      if (arm && !was_arm) begin
        sw = slv_word << (16 - slv_n);
        ec = 0; mw = '0; prev_sclk = sclk;
      end else if (arm && sclk != prev_sclk) begin
        lead = (sclk != slv_pol);
        if (lead ^ slv_pha) mw = {mw[14:0], mosi};
        else if (!(slv_pha && ec == 0)) sw = sw << 1;
        ec++;
        prev_sclk = sclk;
        if (ec == 2 * slv_n) begin
          if (exp_mosi_q.size() == 0) chk(1'b0, "R2 mosi word unexpected", mw, 0);
          else begin
            e = exp_mosi_q.pop_front();
            chk(mw == e, slv_pha ? "R2/R4 mosi word" : "R2/R3 mosi word", mw, e);
          end
        end
      end else begin
        prev_sclk = sclk;
      end
      was_arm = arm;
      if (rx_valid) begin
        chk(bit_tick == 1'b1, "R8 rx_valid on sampling tick", bit_tick, 1);
        if (exp_rx_q.size() == 0) chk(1'b0, "R6 unexpected rx word", rx_data, 0);
        else begin
          e = exp_rx_q.pop_front();
          chk(rx_data == e, "R8 rx word", rx_data, e);
        end
      end
    end
  end

  task automatic send(input logic [3:0] size, input logic pol, input logic pha,
                      input logic lb, input logic [15:0] txw, input logic [15:0] slw);
    int n;
    logic [15:0] mask;
    n = (size < 3) ? 4 : int'(size) + 1;
    mask = (n == 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
    @(negedge clk);
    arm = 1'b0;
    cfg_size = size; cfg_pol = pol; cfg_phase = pha; cfg_loop = lb; cfg_en = 1'b1;
    repeat (3) @(negedge clk);
    slv_n = n; slv_pol = pol; slv_pha = pha; slv_word = slw; arm = 1'b1;
    exp_mosi_q.push_back(txw & mask);
    exp_rx_q.push_back(lb ? (txw & mask) : (slw & mask));   // R7 when lb
    tx_data = txw; tx_valid = 1'b1;
    #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    tx_valid = 1'b0;
    #1;
    chk(busy == 1'b1, "R9 busy during frame", busy, 1);
    while (busy) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    chk(sclk == pol, "R5 sclk idle after frame", sclk, pol);
    chk(ec == 2 * n, "R10 edge count (R1 length)", ec, 2 * n);
    chk(exp_rx_q.size() == 0, "R8 rx word delivered", exp_rx_q.size(), 0);
    arm = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    miscompares++; vectors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit seen_ready;
    bit sclk_moved;
    logic s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(sclk == 1'b0, "R5 reset sclk idle", sclk, 0);
    chk(busy == 1'b0, "R9 reset busy", busy, 0);
    chk(rx_valid == 1'b0, "R8 reset rx_valid", rx_valid, 0);
    chk(tx_ready == 1'b0, "R6 reset tx_ready", tx_ready, 0);

    send(4'd7,  1'b0, 1'b0, 1'b0, 16'h00A5, 16'h003C);
    send(4'd7,  1'b0, 1'b1, 1'b0, 16'h005A, 16'h00C3);
    send(4'd7,  1'b1, 1'b0, 1'b0, 16'h0096, 16'h0069);
    send(4'd7,  1'b1, 1'b1, 1'b0, 16'h00F0, 16'h000F);
    send(4'd15, 1'b0, 1'b0, 1'b0, 16'hBEEF, 16'h1234);
    send(4'd15, 1'b1, 1'b1, 1'b0, 16'h8001, 16'hF00D);
    send(4'd4,  1'b0, 1'b0, 1'b0, 16'hFFF3, 16'hFFEA);  // R2 upper bits ignored
    send(4'd3,  1'b1, 1'b0, 1'b0, 16'hABCD, 16'h0005);  // R1 shortest legal
    send(4'd1,  1'b0, 1'b1, 1'b0, 16'h0009, 16'h0006);  // R1 clamp to 4
    send(4'd11, 1'b0, 1'b0, 1'b1, 16'h0ABC, 16'h0555);  // R7 loopback
    send(4'd15, 1'b1, 1'b1, 1'b1, 16'hC3A5, 16'h0000);  // R7 loopback

    // R6: enable low holds the word off
    @(negedge clk);
    cfg_en = 1'b0; cfg_pol = 1'b0; tx_data = 16'h1111; tx_valid = 1'b1;
    seen_ready = 1'b0; sclk_moved = 1'b0;
    #1; s0 = sclk;
    repeat (30) begin
      @(negedge clk); #1;
      if (tx_ready) seen_ready = 1'b1;
      if (sclk != s0) sclk_moved = 1'b1;
    end
    chk(!seen_ready, "R6 no accept while disabled", seen_ready, 0);
    chk(!sclk_moved, "R6 sclk still while disabled", sclk_moved, 0);
    chk(busy == 1'b1, "R9 busy with pending word", busy, 1);
    @(negedge clk); tx_valid = 1'b0;
    #1;
    chk(busy == 1'b0, "R9 idle busy low", busy, 0);

    // R6: abort mid-frame
    @(negedge clk);
    cfg_size = 4'd15; cfg_pol = 1'b1; cfg_phase = 1'b0; cfg_loop = 1'b0; cfg_en = 1'b1;
    tx_data = 16'h7E7E; tx_valid = 1'b1;
    #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    @(negedge clk); tx_valid = 1'b0;
    repeat (10) @(negedge clk);
    cfg_en = 1'b0;
    @(negedge clk); #1;
    chk(sclk == 1'b1, "R6 abort returns sclk idle", sclk, 1);
    chk(busy == 1'b0, "R6 abort clears busy", busy, 0);
    repeat (120) @(negedge clk);
    chk(exp_rx_q.size() == 0, "R6 nothing queued after abort", exp_rx_q.size(), 0);

    // recover after abort
    send(4'd7, 1'b0, 1'b0, 1'b0, 16'h0033, 16'h00CC);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule